// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. It supports 4 KB pages, and 4 MB pages whose directory entry also supplies eight extra physical address bits, so the result is 40 bits wide. A request carries the virtual address, the access kind (read, write or instruction fetch) and the privilege level. The walker reads the control state it needs (paging enable, write-protect, large-page enable, the A20 gate and the table root) at the moment it accepts the request.

The walker has a single-outstanding memory port. It fetches the directory entry and, on the 4 KB path, the table entry. It writes back the accessed bit and, on writes, the dirty bit as part of the walk. It then ends with a one-cycle `done` pulse that reports either a fault with an error code, or the physical address with a write-permission flag meant for a translation cache. The flag is withheld from clean pages, so a later write walks again and marks the page dirty.

Top module: `xlate_walker`

## Requirements
- R1: With paging disabled, an accepted request completes one cycle later with no memory traffic, no fault, write permission granted, and physical address equal to the zero-extended virtual address under the A20 gate.
- R2: The directory entry is read at {root frame, VA[31:22], 2'b00}, with bit 20 forced to 0 when the A20 gate is closed.
- R3: On the 4 KB path the table entry is read at {directory entry[31:12], VA[21:12], 2'b00}, gated the same way, and the physical address is {8'h00, table entry[31:12], VA[11:0]}.
- R4: A directory or table entry with bit 0 (present) clear ends the walk with a fault whose error code has bit 0 clear. The error code layout is bit 0 protection, bit 1 write, bit 2 user, bit 3 reserved-bit.
- R5: When the directory entry has bit 7 set and large pages are enabled, the page is 4 MB with physical address {dir[20:13], dir[31:22], VA[21:0]}. If bit 21 of such an entry is set, the result is a fault with error code bits 3 and 0 set. With large pages disabled, bit 7 is ignored and the 4 KB path is taken.
- R6: User (bit 2) and writable (bit 1) rights are the AND of both levels. A user access to a supervisor page faults with bit 0 set. A write to a read-only page faults in user mode, and in supervisor mode only when write-protect is on.
- R7: On the 4 KB path a directory entry with bit 5 (accessed) clear is written back with bit 5 set before the table entry is read.
- R8: A leaf entry is written back with bit 5 set, and with bit 6 (dirty) also set on writes, only when this changes its value. A walk that faults writes no leaf.
- R9: Write permission is reported only when the page is writable for this requester and its dirty bit is set after the walk.
- R10: When the A20 gate is closed, physical bit 20 is forced to 0 on the unpaged and 4 KB paths. On the 4 MB path, bit 20 comes from the virtual address unchanged.
- R11: A fetch is checked and reported like a read: error code bit 1 clear, and no dirty update.
- R12: `req_ready` is high only while idle. A memory request stays asserted with stable address until accepted, and `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Request from user privilege |
| cfg_paging | input | 1 | Paging enable |
| cfg_wp | input | 1 | Supervisor write-protect |
| cfg_pse | input | 1 | 4 MB page enable |
| cfg_a20 | input | 1 | A20 gate open |
| cfg_root_frame | input | 20 | Directory base, bits 31:12 |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Access is a write |
| mem_req_addr | output | 32 | Byte address of the 32-bit word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| done_fault | output | 1 | Walk ended in a page fault |
| done_err | output | 4 | Fault error code |
| done_paddr | output | 40 | Translated physical address |
| done_wr_ok | output | 1 | Write permission for the page |
| done_big | output | 1 | Translation is a 4 MB page |

## Verification
A corrupted copy of a fetched entry shows at the ports within a few cycles: either the next memory address strays from the table-index formula, or the final address and write flag disagree with the bench's walk of its own copy of memory. A wrong write-back decision leaves a table word in memory that differs from the model, and the bench compares that word right after `done`. A stuck or misrouted state shows as a missing `done` or as a memory request on a walk that should have none. Random tables with random control settings are mixed with directed cases for each fault kind and for the A20 edge.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int ADDR_W  = 32;
  localparam int PA_W    = 40;
  localparam int PAGE_SH = 12;
  localparam int DIR_SH  = 22;
  localparam int HI_W    = PA_W - ADDR_W;
  localparam int FRAME_W = ADDR_W - PAGE_SH;
  localparam int ERR_W   = 4;

  // entry bit positions (hardware table format)
  localparam int E_PRES = 0;
  localparam int E_RW   = 1;
  localparam int E_US   = 2;
  localparam int E_ACC  = 5;
  localparam int E_DIRT = 6;
  localparam int E_BIG  = 7;
  localparam int E_BRSV = 21;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/xw_addr.sv
module xw_addr
  import xw_pkg::*;
#(
  parameter int A20_BIT = 20
) (
  input  logic [FRAME_W-1:0] root_frame,
  input  logic [ADDR_W-1:0]  va,
  input  logic [FRAME_W-1:0] dir_frame,
  input  logic [FRAME_W-1:0] leaf_frame,
  input  logic               a20_on,
  output logic [ADDR_W-1:0]  dir_addr,
  output logic [ADDR_W-1:0]  tbl_addr,
  output logic [PA_W-1:0]    pa_flat,
  output logic [PA_W-1:0]    pa_small,
  output logic [PA_W-1:0]    pa_big
);
  localparam int IDX_W = DIR_SH - PAGE_SH;

  logic [ADDR_W-1:0] amask;

  always_comb begin
    amask    = ~(ADDR_W'(!a20_on) << A20_BIT);
    dir_addr = {root_frame, va[ADDR_W-1:DIR_SH], 2'b00} & amask;
    tbl_addr = {dir_frame, va[DIR_SH-1:PAGE_SH], 2'b00} & amask;
    pa_flat  = {{HI_W{1'b0}}, va & amask};
    pa_small = {{HI_W{1'b0}}, leaf_frame & amask[ADDR_W-1:PAGE_SH],
                va[PAGE_SH-1:0]};
    // large page: entry bits 20:13 give the physical bits above 31
    pa_big   = {dir_frame[1 +: HI_W], dir_frame[FRAME_W-1 -: IDX_W],
                va[DIR_SH-1:0]};
  end
endmodule

// File: rtl/xw_check.sv
module xw_check
  import xw_pkg::*;
(
  input  logic              dir_us,
  input  logic              dir_rw,
  input  logic [ADDR_W-1:0] leaf,
  input  logic              is_write,
  input  logic              is_user,
  input  logic              wp_on,
  output logic              prot_fault,
  output logic              leaf_upd,
  output logic              grant_w,
  output logic [ADDR_W-1:0] leaf_new
);
  logic eff_us, eff_rw, may_write;

  always_comb begin
    eff_us     = dir_us & leaf[E_US];
    eff_rw     = dir_rw & leaf[E_RW];
    may_write  = eff_rw | (!is_user & !wp_on);
    prot_fault = (is_user & !eff_us) | (is_write & !may_write);
    leaf_new   = leaf;
    leaf_new[E_ACC] = 1'b1;
    if (is_write) leaf_new[E_DIRT] = 1'b1;
    leaf_upd   = (leaf_new != leaf);
    grant_w    = may_write & leaf_new[E_DIRT];
  end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
#(
  parameter int A20_BIT = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic [1:0]         req_kind,
  input  logic               req_user,
  input  logic               cfg_paging,
  input  logic               cfg_wp,
  input  logic               cfg_pse,
  input  logic               cfg_a20,
  input  logic [FRAME_W-1:0] cfg_root_frame,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [ADDR_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_rdata,
  output logic               done,
  output logic               done_fault,
  output logic [ERR_W-1:0]   done_err,
  output logic [PA_W-1:0]    done_paddr,
  output logic               done_wr_ok,
  output logic               done_big
);
  typedef enum logic [3:0] {
    S_IDLE, S_DIR_RQ, S_DIR_RS, S_DIRA_RQ, S_DIRA_RS,
    S_TBL_RQ, S_TBL_RS, S_LEAF_RQ, S_LEAF_RS
  } wstate_e;

  wstate_e            st, nxt_st;
  logic [ADDR_W-1:0]  va_q, dir_q, tbl_q, addr_q, wdata_q;
  logic [FRAME_W-1:0] root_q;
  logic               write_q, user_q, wp_q, pse_q, a20_q, big_q;

  logic               idle;
  logic [ADDR_W-1:0]  cur_va, cur_dir, cur_leaf;
  logic [FRAME_W-1:0] cur_root;
  logic               cur_a20, big_now;
  logic [ADDR_W-1:0]  dir_addr, tbl_addr, leaf_new;
  logic [PA_W-1:0]    pa_flat, pa_small, pa_big;
  logic               prot_fault, leaf_upd, grant_w;

  logic               fin, fin_fault, fin_rsvd, fin_p, fin_wr;
  logic [PA_W-1:0]    fin_pa;
  logic [ADDR_W-1:0]  nxt_addr, nxt_wdata;

  assign idle     = (st == S_IDLE);
  assign cur_va   = idle ? req_vaddr : va_q;
  assign cur_root = idle ? cfg_root_frame : root_q;
  assign cur_a20  = idle ? cfg_a20 : a20_q;
  assign cur_dir  = (st == S_DIR_RS) ? mem_rsp_rdata : dir_q;
  assign big_now  = (st == S_DIR_RS) ? (mem_rsp_rdata[E_BIG] & pse_q) : big_q;
  assign cur_leaf = big_now ? cur_dir :
                    ((st == S_TBL_RS) ? mem_rsp_rdata : tbl_q);

  xw_addr #(.A20_BIT(A20_BIT)) u_addr (
    .root_frame (cur_root),
    .va         (cur_va),
    .dir_frame  (cur_dir[ADDR_W-1:PAGE_SH]),
    .leaf_frame (cur_leaf[ADDR_W-1:PAGE_SH]),
    .a20_on     (cur_a20),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr),
    .pa_flat    (pa_flat),
    .pa_small   (pa_small),
    .pa_big     (pa_big)
  );

  xw_check u_check (
    .dir_us     (cur_dir[E_US]),
    .dir_rw     (cur_dir[E_RW]),
    .leaf       (cur_leaf),
    .is_write   (write_q),
    .is_user    (user_q),
    .wp_on      (wp_q),
    .prot_fault (prot_fault),
    .leaf_upd   (leaf_upd),
    .grant_w    (grant_w),
    .leaf_new   (leaf_new)
  );

  assign req_ready     = idle;
  assign mem_req_valid = (st == S_DIR_RQ) || (st == S_DIRA_RQ) ||
                         (st == S_TBL_RQ) || (st == S_LEAF_RQ);
  assign mem_req_write = (st == S_DIRA_RQ) || (st == S_LEAF_RQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  // evaluation of a fetched entry happens in the response cycle itself
  always_comb begin
    nxt_st    = st;
    nxt_addr  = addr_q;
    nxt_wdata = wdata_q;
    fin       = 1'b0;
    fin_fault = 1'b0;
    fin_rsvd  = 1'b0;
    fin_p     = 1'b0;
    fin_wr    = 1'b0;
    fin_pa    = big_now ? pa_big : pa_small;
    unique case (st)
      S_IDLE: if (req_valid) begin
        if (!cfg_paging) begin
          fin    = 1'b1;
          fin_pa = pa_flat;
          fin_wr = 1'b1;
        end else begin
          nxt_addr = dir_addr;
          nxt_st   = S_DIR_RQ;
        end
      end
      S_DIR_RQ:  if (mem_req_ready) nxt_st = S_DIR_RS;
      S_DIRA_RQ: if (mem_req_ready) nxt_st = S_DIRA_RS;
      S_TBL_RQ:  if (mem_req_ready) nxt_st = S_TBL_RS;
      S_LEAF_RQ: if (mem_req_ready) nxt_st = S_LEAF_RS;
      S_DIR_RS: if (mem_rsp_valid) begin
        if (!mem_rsp_rdata[E_PRES]) begin
          fin = 1'b1; fin_fault = 1'b1;
        end else if (big_now) begin
          if (mem_rsp_rdata[E_BRSV]) begin
            fin = 1'b1; fin_fault = 1'b1; fin_rsvd = 1'b1; fin_p = 1'b1;
          end else if (prot_fault) begin
            fin = 1'b1; fin_fault = 1'b1; fin_p = 1'b1;
          end else if (leaf_upd) begin
            nxt_wdata = leaf_new;
            nxt_st    = S_LEAF_RQ;
          end else begin
            fin = 1'b1; fin_wr = grant_w;
          end
        end else if (!mem_rsp_rdata[E_ACC]) begin
          nxt_wdata = mem_rsp_rdata | (ADDR_W'(1) << E_ACC);
          nxt_st    = S_DIRA_RQ;
        end else begin
          nxt_addr = tbl_addr;
          nxt_st   = S_TBL_RQ;
        end
      end
      S_DIRA_RS: if (mem_rsp_valid) begin
        nxt_addr = tbl_addr;
        nxt_st   = S_TBL_RQ;
      end
      S_TBL_RS: if (mem_rsp_valid) begin
        if (!mem_rsp_rdata[E_PRES]) begin
          fin = 1'b1; fin_fault = 1'b1;
        end else if (prot_fault) begin
          fin = 1'b1; fin_fault = 1'b1; fin_p = 1'b1;
        end else if (leaf_upd) begin
          nxt_wdata = leaf_new;
          nxt_st    = S_LEAF_RQ;
        end else begin
          fin = 1'b1; fin_wr = grant_w;
        end
      end
      S_LEAF_RS: if (mem_rsp_valid) begin
        fin = 1'b1; fin_wr = grant_w;
      end
      default: nxt_st = S_IDLE;
    endcase
    if (fin) nxt_st = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      va_q       <= '0;
      dir_q      <= '0;
      tbl_q      <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      root_q     <= '0;
      write_q    <= 1'b0;
      user_q     <= 1'b0;
      wp_q       <= 1'b0;
      pse_q      <= 1'b0;
      a20_q      <= 1'b0;
      big_q      <= 1'b0;
      done       <= 1'b0;
      done_fault <= 1'b0;
      done_err   <= '0;
      done_paddr <= '0;
      done_wr_ok <= 1'b0;
      done_big   <= 1'b0;
    end else begin
      st      <= nxt_st;
      addr_q  <= nxt_addr;
      wdata_q <= nxt_wdata;
      done    <= fin;
      if (idle && req_valid) begin
        va_q    <= req_vaddr;
        write_q <= (req_kind == ACC_WRITE);
        user_q  <= req_user;
        wp_q    <= cfg_wp;
        pse_q   <= cfg_pse;
        a20_q   <= cfg_a20;
        root_q  <= cfg_root_frame;
        big_q   <= 1'b0;
      end
      if (st == S_DIR_RS && mem_rsp_valid) begin
        dir_q <= mem_rsp_rdata;
        big_q <= big_now;
      end
      if (st == S_TBL_RS && mem_rsp_valid) tbl_q <= mem_rsp_rdata;
      if (fin) begin
        done_fault <= fin_fault;
        done_err   <= fin_fault ? {fin_rsvd, user_q, write_q, fin_p} : '0;
        done_paddr <= fin_fault ? '0 : fin_pa;
        done_wr_ok <= !fin_fault && fin_wr;
        done_big   <= !fin_fault && !idle && big_now;
      end
    end
  end
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic cfg_paging,
  input logic mem_req_valid,
  input logic mem_req_ready,
  input logic mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic wdata_acc,
  input logic done,
  input logic done_fault,
  input logic err_rsvd,
  input logic err_p
);
  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
  // R12
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  flat_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !cfg_paging |=> done && !done_fault);
  // R8
  wb_acc_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write |-> wdata_acc);
  // R5
  rsvd_p_chk: assert property (@(posedge clk) disable iff (rst)
    done && done_fault && err_rsvd |-> err_p);
endmodule

bind xlate_walker xlate_walker_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .cfg_paging    (cfg_paging),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .wdata_acc     (mem_req_wdata[5]),
  .done          (done),
  .done_fault    (done_fault),
  .err_rsvd      (done_err[3]),
  .err_p         (done_err[0])
);

// File: tb/tb_xlate_walker.sv
`timescale 1ns/1ps
module tb_xlate_walker;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0, req_user = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic        cfg_paging = 0, cfg_wp = 0, cfg_pse = 0, cfg_a20 = 1;
  logic [19:0] cfg_root_frame = 0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata = 0;
  logic        done, done_fault, done_wr_ok, done_big;
  logic [3:0]  done_err;
  logic [39:0] done_paddr;

  always #10 clk = ~clk;

  xlate_walker dut (.*);

  logic [31:0] mem [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  int n_chk = 0, n_fail = 0, nwr = 0, nlog = 0;
  logic [31:0] log_addr [8];
  logic [31:0] log_wd [8];
  logic        pend = 0;
  logic [31:0] pend_data = 0;

  function automatic logic [31:0] rd_dut(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rd_ref(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
  endfunction
  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a] = v; ref_mem[a] = v;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model: random accept stalls, response one cycle after acceptance
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = pend;
      mem_rsp_rdata = pend_data;
      pend = 0;
      mem_req_ready = ($urandom_range(3) != 0);
      if (!rst && mem_req_valid && mem_req_ready) begin
        if (nlog < 8) begin
          log_addr[nlog] = mem_req_addr;
          log_wd[nlog]   = mem_req_write ? mem_req_wdata : 32'hxxxxxxxx;
        end
        nlog++;
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          nwr++;
          pend_data = 0;
        end else pend_data = rd_dut(mem_req_addr);
        pend = 1;
      end
    end
  end

  // reference walk written from the requirements
  task automatic ref_walk(input logic [31:0] va, input logic [1:0] kind, input logic user,
                          output logic f, output logic [3:0] e, output logic [39:0] pa,
                          output logic w, output logic big, output int nw,
                          output logic [31:0] pdea, output logic [31:0] ptea);
    logic [31:0] mask, pde, pte, leaf, nl;
    logic isw, eu, erw, wok;
    mask = cfg_a20 ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
    f = 0; e = 0; pa = 0; w = 0; big = 0; nw = 0; pdea = 0; ptea = 0;
    isw = (kind == 2'd1);
    if (!cfg_paging) begin
      pa = {8'h0, va & mask}; w = 1; return;
    end
    pdea = {cfg_root_frame, va[31:22], 2'b00} & mask;
    pde  = rd_ref(pdea);
    ptea = {pde[31:12], va[21:12], 2'b00} & mask;
    if (!pde[0]) begin f = 1; e = {1'b0, user, isw, 1'b0}; return; end
    if (pde[7] && cfg_pse) begin
      if (pde[21]) begin f = 1; e = {1'b1, user, isw, 1'b1}; return; end
      big = 1; leaf = pde; ptea = pdea; eu = pde[2]; erw = pde[1];
    end else begin
      if (!pde[5]) begin ref_mem[pdea] = pde | 32'h20; nw++; end
      pte = rd_ref(ptea);
      if (!pte[0]) begin f = 1; e = {1'b0, user, isw, 1'b0}; return; end
      leaf = pte; eu = pde[2] & pte[2]; erw = pde[1] & pte[1];
    end
    wok = erw || (!user && !cfg_wp);
    if ((user && !eu) || (isw && !wok)) begin
      f = 1; e = {1'b0, user, isw, 1'b1}; big = 0; return;
    end
    nl = leaf | 32'h20 | (isw ? 32'h40 : 32'h0);
    if (nl != leaf) begin ref_mem[ptea] = nl; nw++; end
    w  = wok && nl[6];
    pa = big ? {pde[20:13], pde[31:22], va[21:0]}
             : {8'h0, leaf[31:12] & mask[31:12], va[11:0]};
  endtask

  task automatic run_case(input string tag, input logic [31:0] va,
                          input logic [1:0] kind, input logic user);
    logic ef, ew, eb;
    logic [3:0] ee;
    logic [39:0] ep;
    logic [31:0] pdea, ptea;
    int enw, cnt;
    ref_walk(va, kind, user, ef, ee, ep, ew, eb, enw, pdea, ptea);
    nwr = 0; nlog = 0;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_user = user; req_valid = 1;
    cnt = 0;
    while (!req_ready && cnt < 100) begin @(negedge clk); cnt++; end
    @(negedge clk);
    req_valid = 0;
    cnt = 0;
    while (!done && cnt < 3000) begin @(negedge clk); cnt++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL %s watchdog act=no_done exp=done", tag);
      return;
    end
    chk({tag, " fault"}, 64'(done_fault), 64'(ef));
    chk({tag, " err"}, 64'(done_err), 64'(ee));
    if (!ef) begin
      chk({tag, " paddr"}, 64'(done_paddr), 64'(ep));
      chk({tag, " wr_ok"}, 64'(done_wr_ok), 64'(ew));
      chk({tag, " big"}, 64'(done_big), 64'(eb));
    end
    chk({tag, " writes"}, 64'(nwr), 64'(enw));
    if (cfg_paging) begin
      chk({tag, " dir mem"}, 64'(rd_dut(pdea)), 64'(rd_ref(pdea)));
      chk({tag, " leaf mem"}, 64'(rd_dut(ptea)), 64'(rd_ref(ptea)));
    end
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset done", 64'(done), 64'd0);
    chk("R12 reset ready", 64'(req_ready), 64'd1);
    chk("R12 reset memreq", 64'(mem_req_valid), 64'd0);

    // R1 / R10 unpaged, gate closed
    cfg_paging = 0; cfg_a20 = 0;
    run_case("R1", 32'h1234_5678, 2'd0, 1'b1);
    chk("R10 flat bit20", 64'(done_paddr), 64'h00_1224_5678);
    chk("R1 no traffic", 64'(nlog), 64'd0);

    cfg_paging = 1; cfg_a20 = 1; cfg_wp = 0; cfg_pse = 1;
    cfg_root_frame = 20'h00040;
    put(32'h0004_0004, 32'h0008_0007);
    put(32'h0008_000C, 32'h0123_4007);
    run_case("R9 clean read", 32'h0040_3ABC, 2'd0, 1'b1);
    chk("R3 paddr", 64'(done_paddr), 64'h00_0123_4ABC);
    chk("R9 clean no write", 64'(done_wr_ok), 64'd0);
    chk("R2 dir addr", 64'(log_addr[0]), 64'h0004_0004);
    chk("R7 dir writeback", 64'(log_wd[1]), 64'h0008_0027);
    chk("R3 tbl addr", 64'(log_addr[2]), 64'h0008_000C);
    run_case("R8 write dirty", 32'h0040_3ABC, 2'd1, 1'b1);
    chk("R8 leaf value", 64'(rd_dut(32'h0008_000C)), 64'h0123_4067);
    run_case("R8 unchanged", 32'h0040_3ABC, 2'd0, 1'b1);
    chk("R8 no write", 64'(nwr), 64'd0);

    run_case("R11 fetch absent", 32'h0040_4000, 2'd2, 1'b1);
    chk("R4 err absent", 64'(done_err), 64'h4);
    put(32'h0008_0014, 32'h0055_5005);
    run_case("R11 fetch ro", 32'h0040_5000, 2'd2, 1'b1);
    chk("R11 no dirty", 64'(rd_dut(32'h0008_0014)), 64'h0055_5025);

    put(32'h0008_0014, 32'h0055_5005);
    run_case("R6 sup write wp0", 32'h0040_5000, 2'd1, 1'b0);
    put(32'h0008_0014, 32'h0055_5005);
    cfg_wp = 1;
    run_case("R6 sup write wp1", 32'h0040_5000, 2'd1, 1'b0);
    chk("R6 err wp", 64'(done_err), 64'h3);
    cfg_wp = 0;

    put(32'h0004_0008, 32'h0009_0003);
    put(32'h0009_0000, 32'h0077_7007);
    run_case("R6 dir supervisor", 32'h0080_0000, 2'd0, 1'b1);
    chk("R6 err user", 64'(done_err), 64'h5);

    put(32'h0004_000C, 32'h0C84_A0A7);
    run_case("R5 large", 32'h00D5_4321, 2'd0, 1'b0);
    chk("R5 large paddr", 64'(done_paddr), 64'h25_0C95_4321);
    cfg_a20 = 0;
    run_case("R10 large gate", 32'h00D5_4321, 2'd0, 1'b0);
    chk("R10 large bit20", 64'(done_paddr), 64'h25_0C95_4321);
    cfg_a20 = 1; cfg_pse = 0;
    put(32'h0C84_A550, 32'h0);
    run_case("R5 pse off", 32'h00D5_4321, 2'd0, 1'b0);
    cfg_pse = 1;
    put(32'h0004_000C, 32'h0CA4_A0A7);
    run_case("R5 rsvd", 32'h00D5_4321, 2'd0, 1'b1);
    chk("R5 err rsvd", 64'(done_err), 64'hD);

    put(32'h0004_0010, 32'h0);
    run_case("R4 dir absent", 32'h0100_0000, 2'd1, 1'b0);
    chk("R4 err", 64'(done_err), 64'h2);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] va, pde, pte, m, pa_d;
      cfg_paging = ($urandom_range(9) != 0);
      cfg_wp  = $urandom_range(1);
      cfg_pse = $urandom_range(1);
      cfg_a20 = $urandom_range(1);
      cfg_root_frame = 20'($urandom);
      va  = $urandom;
      m   = cfg_a20 ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
      pde = $urandom;
      pde[0] = ($urandom_range(7) != 0);
      pde[21] = ($urandom_range(5) == 0);
      pte = $urandom;
      pte[0] = ($urandom_range(7) != 0);
      pa_d = {cfg_root_frame, va[31:22], 2'b00} & m;
      put(pa_d, pde);
      put({pde[31:12], va[21:12], 2'b00} & m, pte);
      run_case("rand R6 R8 R9", va, 2'($urandom_range(2)), 1'($urandom_range(1)));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 global watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule